// File: doc/BRIEF.md
# DMA Request-Grant Handshake Controller

This block sits on the processor side of an external DMA channel. A device asks for a transfer by pulling an active-low request line. The block synchronises that line, recognises the request and runs one bus access for it. During the access it drives an active-low grant strobe, which tells the external logic when to latch or drive data, together with the matching active-low read or write strobe. The grant and the strobe fall in the same cycle and rise in the same cycle.

The length of an access comes from a wait-state count, sampled when the access starts. A device that keeps its request low past the normal end of the access holds the access open one cycle per clock. An optional recovery cycle keeps the strobes high for one extra cycle after each access. In paced mode the access runs on the read or write strobe alone and the grant stays high. Request recognition can be level-based (synchronous mode) or edge-based with capture (asynchronous mode). A one-cycle completion pulse marks the end of every access.

Top module: `dma_hs_ctrl`

## Requirements
- R1: While reset is held low, and on the first clock after it, `grant_n`, `rd_n` and `wr_n` are high and `done` is low.
- R2: In synchronous mode (`sync_mode`=1) a request that is low at a clock edge, after the two-flop synchroniser, starts an access. The strobe is first low in the cycle after the third rising edge that follows `req_n` going low.
- R3: If the request is released in time, the strobe and the grant stay low for exactly 1 + W cycles, where W is `wait_states` at the start of the access.
- R4: If the synchronised request is still low when the wait count runs out, the access is held one cycle per clock until the request is released. For a request low for L cycles, the low time is max(1 + W, L).
- R5: `is_write`=1 selects `wr_n` and `is_write`=0 selects `rd_n`. The two are never low together, and in the handshake modes `grant_n` is low in exactly the cycles where the selected strobe is low.
- R6: Mode encoding: 2'b00 handshake, 2'b01 external handshake, 2'b10 paced, 2'b11 handled as handshake. In paced mode `grant_n` stays high for the whole access while the strobe timing is unchanged.
- R7: With `idle_en`=0 the strobes are high for at least one cycle between two accesses. With `idle_en`=1 latched for the finished access, they are high for at least two cycles.
- R8: `done` is high for exactly one cycle: the first cycle in which the strobe is high again after an access.
- R9: In asynchronous mode (`sync_mode`=0) a falling edge of the synchronised request is recorded even while an access is running, and a recorded edge starts one access once the block is idle. In synchronous mode a request that is no longer low when the block is idle is ignored.
- R10: Mode, direction, wait count and recovery enable are captured when the access starts. Changes to them during the access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | Active-low transfer request, asynchronous to clk |
| sync_mode | input | 1 | 1: level recognition, 0: edge recognition with capture |
| mode | input | 2 | Transfer mode (00 handshake, 01 external handshake, 10 paced) |
| is_write | input | 1 | 1: write access, 0: read access |
| wait_states | input | WAIT_W | Extra low cycles W added to each access |
| idle_en | input | 1 | Adds one recovery cycle after each access |
| grant_n | output | 1 | Active-low grant strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: the wait counter running out, and the stretch test on the still-low request. The bench makes them meet by holding the request for exactly 1 + W cycles, and also one cycle longer and well shorter. It then judges the low time against max(1 + W, L). A second meeting point is a new asynchronous request edge that arrives while an access is still counting. The bench sends a second short pulse into the wait window and judges it by the number of completion pulses and by the high gap between the two accesses, with and without the recovery cycle.

// File: rtl/dma_hs_pkg.sv
// Shared types for the DMA handshake controller.
// Assumes: the mode encoding below is also the encoding of the top-level mode pin.
package dma_hs_pkg;

    typedef enum logic [1:0] {
        MODE_HS    = 2'b00,
        MODE_XHS   = 2'b01,
        MODE_PACED = 2'b10,
        MODE_RSV   = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_ACTIVE  = 2'b01,
        ST_RECOVER = 2'b10
    } seq_state_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       write;
        logic       idle_en;
    } acc_cfg_t;

endpackage

// File: rtl/dma_hs_req_sync.sv
// Request front end: synchronises the active-low request and turns it into
// a start qualifier for the sequencer.
// Level mode: start follows the synchronised level.
// Edge mode: a rising edge of the synchronised (active-high) request is kept
// pending until the sequencer takes it.
// Assumes: STAGES >= 2, and req_n idles high.
module dma_hs_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic sync_mode,
    input  logic take,
    output logic req_lvl,
    output logic req_start
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              pend_q;
    logic              rise;

    // Synchroniser chain, filled with the idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], req_n};
        end
    end

    assign req_lvl = ~chain_q[STAGES-1];
    assign rise    = req_lvl & ~prev_q;

    // Edge history and capture of requests that arrive while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req_lvl;
            pend_q <= ~sync_mode & (pend_q | rise) & ~take;
        end
    end

    // Start qualifier chosen by the recognition mode.
    always_comb begin
        if (sync_mode) begin
            req_start = req_lvl;
        end else begin
            req_start = rise | pend_q;
        end
    end

endmodule

// File: rtl/dma_hs_seq.sv
// Access sequencer: IDLE -> ACTIVE (1 + W cycles, stretched while the request
// stays low) -> optional RECOVER -> IDLE. Captures the configuration at the
// start of each access and raises done for one cycle at the end.
// Assumes: req_start and req_lvl come from registered logic.
module dma_hs_seq #(
    parameter int WAIT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_start,
    input  logic                  req_lvl,
    input  dma_hs_pkg::acc_cfg_t  cfg_in,
    input  logic [WAIT_W-1:0]     wait_in,
    output logic                  take,
    output logic                  active,
    output dma_hs_pkg::acc_cfg_t  cfg_q,
    output logic                  done
);
    import dma_hs_pkg::*;

    seq_state_e        state_q;
    logic [WAIT_W-1:0] cnt_q;

    assign take   = (state_q == ST_IDLE) & req_start;
    assign active = (state_q == ST_ACTIVE);

    // State, wait counter, captured configuration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '{mode: MODE_HS, write: 1'b0, idle_en: 1'b0};
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        state_q <= ST_ACTIVE;
                        cnt_q   <= wait_in;
                        cfg_q   <= cfg_in;
                    end
                end
                ST_ACTIVE: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!req_lvl) begin
                        done    <= 1'b1;
                        state_q <= cfg_q.idle_en ? ST_RECOVER : ST_IDLE;
                    end
                end
                ST_RECOVER: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/dma_hs_strobe.sv
// Strobe decode: turns the active flag and the captured configuration into
// the active-low grant, read and write strobes.
// Assumes: active and cfg come straight from flops, so the outputs are clean.
module dma_hs_strobe (
    input  logic                 active,
    input  dma_hs_pkg::acc_cfg_t cfg,
    output logic                 grant_n,
    output logic                 rd_n,
    output logic                 wr_n
);
    import dma_hs_pkg::*;

    // Grant follows the strobe except in paced mode.
    always_comb begin
        rd_n    = ~(active & ~cfg.write);
        wr_n    = ~(active &  cfg.write);
        grant_n = ~(active & (cfg.mode != MODE_PACED));
    end

endmodule

// File: rtl/dma_hs_ctrl.sv
// Top of the DMA request-grant handshake controller. Connects the request
// front end, the access sequencer and the strobe decode.
// Assumes: configuration inputs are synchronous to clk; req_n may be asynchronous.
module dma_hs_ctrl #(
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic              sync_mode,
    input  logic [1:0]        mode,
    input  logic              is_write,
    input  logic [WAIT_W-1:0] wait_states,
    input  logic              idle_en,
    output logic              grant_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done
);
    import dma_hs_pkg::*;

    logic     req_lvl;
    logic     req_start;
    logic     take;
    logic     active;
    acc_cfg_t cfg_in;
    acc_cfg_t cfg_q;

    // Assemble the configuration captured at the start of an access.
    always_comb begin
        cfg_in.mode    = xfer_mode_e'(mode);
        cfg_in.write   = is_write;
        cfg_in.idle_en = idle_en;
    end

    dma_hs_req_sync #(.STAGES(SYNC_STAGES)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_n),
        .sync_mode (sync_mode),
        .take      (take),
        .req_lvl   (req_lvl),
        .req_start (req_start)
    );

    dma_hs_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (req_start),
        .req_lvl   (req_lvl),
        .cfg_in    (cfg_in),
        .wait_in   (wait_states),
        .take      (take),
        .active    (active),
        .cfg_q     (cfg_q),
        .done      (done)
    );

    dma_hs_strobe u_stb (
        .active  (active),
        .cfg     (cfg_q),
        .grant_n (grant_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n)
    );

endmodule

// File: rtl/dma_hs_chk.sv
// Property checker for the DMA handshake controller, bound to the top module.
// Assumes: it sees the sequencer's active flag and captured configuration.
module dma_hs_chk (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 grant_n,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 done,
    input logic                 active,
    input dma_hs_pkg::acc_cfg_t cfg_q
);
    import dma_hs_pkg::*;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (grant_n && rd_n && wr_n && !done));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_grant_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_n |-> (!rd_n || !wr_n));

    assert_paced_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cfg_q.mode == MODE_PACED) |-> grant_n);

    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.idle_en && $rose(rd_n && wr_n)) |=> (rd_n && wr_n));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n));

endmodule

bind dma_hs_ctrl dma_hs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_n (grant_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .done    (done),
    .active  (active),
    .cfg_q   (cfg_q)
);

// File: tb/sim_dma_hs_ctrl.sv
module sim_dma_hs_ctrl;

    localparam int CLK_P  = 10;
    localparam int WAIT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_n = 1'b1;
    logic              sync_mode = 1'b1;
    logic [1:0]        mode = 2'b00;
    logic              is_write = 1'b0;
    logic [WAIT_W-1:0] wait_states = '0;
    logic              idle_en = 1'b0;
    logic              grant_n, rd_n, wr_n, done;

    int n_chk = 0;
    int n_bad_chk = 0;

    // Monitor accumulators, cleared by each scenario.
    bit mon_on = 1'b0;
    int smp, n_rd, n_wr, n_gnt, n_done, n_mis, first_low, hi_run, min_gap;
    bit prev_low, seen_end;

    dma_hs_ctrl #(.WAIT_W(WAIT_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .sync_mode(sync_mode),
        .mode(mode), .is_write(is_write), .wait_states(wait_states),
        .idle_en(idle_en), .grant_n(grant_n), .rd_n(rd_n), .wr_n(wr_n),
        .done(done)
    );

    always #(CLK_P/2) clk = ~clk;

    // Samples outputs a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (mon_on) begin
            bit low;
            low = !rd_n || !wr_n;
            smp++;
            if (!rd_n) n_rd++;
            if (!wr_n) n_wr++;
            if (!grant_n) n_gnt++;
            if (done) n_done++;
            if (!grant_n && rd_n && wr_n) n_mis++;
            if (!rd_n && !wr_n) n_mis++;
            if (low && first_low == 0) first_low = smp;
            if (low && !prev_low && seen_end && hi_run < min_gap) min_gap = hi_run;
            if (!low && prev_low) seen_end = 1'b1;
            if (!low) hi_run++; else hi_run = 0;
            prev_low = low;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad_chk++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        smp = 0; n_rd = 0; n_wr = 0; n_gnt = 0; n_done = 0; n_mis = 0;
        first_low = 0; hi_run = 0; min_gap = 99; prev_low = 1'b0; seen_end = 1'b0;
        mon_on = 1'b1;
    endtask

    task automatic setup(input bit sm, input logic [1:0] md, input bit wr,
                         input int w, input bit idl);
        @(negedge clk);
        sync_mode = sm; mode = md; is_write = wr;
        wait_states = WAIT_W'(w); idle_en = idl;
        repeat (3) @(negedge clk);
    endtask

    // One request pulse of len cycles, then a quiet window.
    task automatic pulse_run(input int len);
        @(negedge clk);
        clear_mon();
        req_n = 1'b0;
        repeat (len) @(negedge clk);
        req_n = 1'b1;
        repeat (30) @(negedge clk);
        mon_on = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "grant_n in reset", int'(grant_n), 1);
        chk("R1", "rd_n in reset", int'(rd_n), 1);
        chk("R1", "wr_n in reset", int'(wr_n), 1);
        chk("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobes after reset", int'(grant_n & rd_n & wr_n), 1);
    endtask

    task automatic t_basic_read();
        setup(1'b1, 2'b00, 1'b0, 0, 1'b0);
        pulse_run(1);
        chk("R2", "first low sample", first_low, 3);
        chk("R3", "rd low cycles W=0", n_rd, 1);
        chk("R5", "wr low on read", n_wr, 0);
        chk("R5", "grant low cycles", n_gnt, 1);
        chk("R5", "grant/strobe mismatch", n_mis, 0);
        chk("R8", "done pulses", n_done, 1);
    endtask

    task automatic t_write_wait();
        setup(1'b1, 2'b00, 1'b1, 3, 1'b0);
        pulse_run(1);
        chk("R3", "wr low cycles W=3", n_wr, 4);
        chk("R5", "rd low on write", n_rd, 0);
        chk("R5", "grant low cycles W=3", n_gnt, 4);
        chk("R8", "done pulses write", n_done, 1);
    endtask

    task automatic t_stretch(input int w, input int len);
        int exp_low;
        exp_low = (len > 1 + w) ? len : 1 + w;
        setup(1'b1, 2'b00, 1'b0, w, 1'b0);
        pulse_run(len);
        chk("R4", $sformatf("rd low W=%0d L=%0d", w, len), n_rd, exp_low);
        chk("R4", "grant matches stretched strobe", n_gnt, exp_low);
        chk("R8", "one done per stretched access", n_done, 1);
    endtask

    task automatic t_paced();
        setup(1'b1, 2'b10, 1'b0, 2, 1'b0);
        pulse_run(1);
        chk("R6", "grant low in paced", n_gnt, 0);
        chk("R6", "rd low in paced", n_rd, 3);
        chk("R8", "done in paced", n_done, 1);
    endtask

    task automatic t_ext_hs();
        setup(1'b1, 2'b01, 1'b1, 1, 1'b0);
        pulse_run(1);
        chk("R6", "grant low in external handshake", n_gnt, 2);
        chk("R6", "wr low in external handshake", n_wr, 2);
    endtask

    // Second short pulse lands inside the wait window of the first access.
    task automatic t_two_pulse(input bit sm, input bit idl);
        setup(sm, 2'b00, 1'b0, 2, idl);
        @(negedge clk);
        clear_mon();
        req_n = 1'b0;
        @(negedge clk); req_n = 1'b1;
        @(negedge clk); req_n = 1'b0;
        @(negedge clk); req_n = 1'b1;
        repeat (30) @(negedge clk);
        mon_on = 1'b0;
        if (sm) begin
            chk("R9", "sync: late pulse ignored, done", n_done, 1);
            chk("R9", "sync: late pulse ignored, rd low", n_rd, 3);
        end else begin
            chk("R9", "async: captured edge served, done", n_done, 2);
            chk("R9", "async: rd low total", n_rd, 6);
            chk("R7", $sformatf("min high gap idle_en=%0d", idl), min_gap, idl ? 2 : 1);
        end
    endtask

    task automatic t_cfg_hold();
        setup(1'b1, 2'b00, 1'b1, 3, 1'b0);
        @(negedge clk);
        clear_mon();
        req_n = 1'b0;
        @(negedge clk); req_n = 1'b1;
        repeat (2) @(negedge clk);
        is_write = 1'b0; wait_states = '0; mode = 2'b10; idle_en = 1'b1;
        repeat (30) @(negedge clk);
        mon_on = 1'b0;
        chk("R10", "wr low kept after cfg change", n_wr, 4);
        chk("R10", "rd untouched by cfg change", n_rd, 0);
        chk("R10", "grant kept after mode change", n_gnt, 4);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_read();
        t_write_wait();
        t_stretch(1, 6);
        t_stretch(4, 3);
        t_stretch(2, 3);
        t_stretch(2, 4);
        t_paced();
        t_ext_hs();
        t_two_pulse(1'b0, 1'b0);
        t_two_pulse(1'b0, 1'b1);
        t_two_pulse(1'b1, 1'b0);
        t_cfg_hold();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad_chk);
        $finish;
    end

endmodule